// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block turns an ordinary accumulator into a test-per-clock stimulus source in which every output bit carries one of three weights: held at 0, held at 1, or pseudorandom. The accumulator has a pattern register A, an unmodified adder (ripple or parallel-prefix, picked by a parameter) and an operand register B. A fixed bit is made by writing complementary values into A[i] and B[i]. That stage then hands its incoming carry on unchanged, so the free bits on either side still behave as one contiguous accumulator.

A session controller walks through `SESSIONS` weight assignments, and each one lasts `SESSION_LEN` clocks. A decoder turns the current session index into paired set/clear vectors. The set line of A[i] is also the clear line of B[i], and the other way round. A pulse on `start` seeds the run. The block then issues one pattern per clock until every session has run, raises `done` and freezes its outputs until the next start.

Top module: `tw_pattern_gen`

## Requirements
- R1: While reset is held, and after it until the first start, `pattern` is 0, `session_idx` is 0 and `done` is 0.
- R2: A `start` sampled high while no run is in progress begins a run. One clock later `pattern` shows the first pattern: bits forced by session 0 take their forced value, all other bits are 0, `session_idx` is 0 and `done` is 0.
- R3: The weight of bit i in session s is the 2-bit field `weight_table[2*(s*WIDTH+i)+1 : 2*(s*WIDTH+i)]`. Code 2'b10 forces the bit to 1, code 2'b01 forces it to 0, and codes 2'b00 and 2'b11 leave it pseudorandom.
- R4: A forced bit shows its forced value in every cycle of its session.
- R5: After every register update, each forced bit of B holds the complement of the same bit of A. Each free bit of B holds the `addend` bit captured at start.
- R6: Each pattern after the first equals (previous A + B) modulo 2^WIDTH, with the forcing of the session the new pattern belongs to applied on top.
- R7: Each session lasts exactly `SESSION_LEN` patterns. `session_idx` steps by one on the first pattern of each new session.
- R8: The clock after the last pattern of the last session, `done` rises. `pattern` and `session_idx` then hold, with `session_idx` equal to `SESSIONS-1`, until the next start.
- R9: A `start` pulse during a run has no effect on the pattern sequence, the session index or `done`.
- R10: A `start` while `done` is high restarts from session 0 and clears `done` on the next clock.
- R11: The ripple and parallel-prefix adder variants produce identical pattern sequences.
- R12: Changes on `addend` after the start clock do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when no run is in progress |
| addend | input | WIDTH | Operand constant, captured at start |
| weight_table | input | 2*SESSIONS*WIDTH | Per-session, per-bit 2-bit weight codes |
| pattern | output | WIDTH | Test pattern (register A) |
| session_idx | output | max(1,clog2(SESSIONS)) | Index of the current weight session |
| done | output | 1 | All sessions finished; outputs frozen |

## Verification
There is one register between `start` and the first pattern, so that pattern and its session index are due on the first falling edge after the start edge. From then on, one new pattern is due per clock. `done` is due one clock after the final pattern, and the final pattern holds from that point. The bench drives inputs and samples outputs on falling edges. It advances its model of A and B exactly once per clock, so each comparison lines up with the register update that produced the value. Stray `start` pulses and `addend` changes in mid-run are applied at falling edges, and their absence of effect is checked on the patterns that follow.

// File: rtl/tw_pkg.sv
// Shared types for the three-weight pattern generator.
// Holds the weight code encoding and its decode into set/clear controls.
package tw_pkg;

    // 2-bit weight code per output bit per session
    typedef enum logic [1:0] {
        WT_RAND   = 2'b00,
        WT_ZERO   = 2'b01,
        WT_ONE    = 2'b10,
        WT_RAND_X = 2'b11
    } weight_e;

    // Force controls for one A/B bit pair, seen from register A
    typedef struct packed {
        logic set_a;
        logic clr_a;
    } force_t;

    // Map a weight code to the set/clear pair; unused code acts as random
    function automatic force_t decode_weight(input logic [1:0] code);
        force_t f;
        f = '0;
        case (weight_e'(code))
            WT_ONE:  f.set_a = 1'b1;
            WT_ZERO: f.clr_a = 1'b1;
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/tw_session_ctrl.sv
// Session sequencer.
// Counts SESSION_LEN clocks per session across SESSIONS sessions and
// raises done after the last one. It tells the datapath when to load,
// when to advance, and whose forcing applies to the value being written.
// Assumes SESSIONS >= 1 and SESSION_LEN >= 1.
module tw_session_ctrl #(
    parameter int SESSIONS    = 2,
    parameter int SESSION_LEN = 8,
    parameter int SW          = 1,
    parameter int CW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic [SW-1:0] apply_sess,
    output logic [SW-1:0] sess_q,
    output logic          busy_q,
    output logic          done_q
);

    logic [CW-1:0] cnt_q;
    logic          last_in_sess;
    logic          last_sess;
    logic          final_cyc;

    // Decode the position inside the run
    always_comb begin
        load         = start && !busy_q;
        last_in_sess = busy_q && (cnt_q == CW'(SESSION_LEN - 1));
        last_sess    = (sess_q == SW'(SESSIONS - 1));
        final_cyc    = last_in_sess && last_sess;
        step         = busy_q && !final_cyc;
    end

    // Pick the session whose forcing the next register value carries
    always_comb begin
        if (load)
            apply_sess = '0;
        else if (last_in_sess)
            apply_sess = sess_q + SW'(1);
        else
            apply_sess = sess_q;
    end

    // Run, session and cycle-count state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sess_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            sess_q <= '0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (final_cyc) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (last_in_sess) begin
                sess_q <= sess_q + SW'(1);
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/tw_force_decode.sv
// Weight decoder.
// Selects the weight codes of one session from the table and expands
// them into per-bit set/clear vectors for register A. Register B uses
// the same lines crossed over. Assumes sel < SESSIONS.
module tw_force_decode #(
    parameter int WIDTH    = 5,
    parameter int SESSIONS = 2,
    parameter int SW       = 1
) (
    input  logic [2*SESSIONS*WIDTH-1:0] weight_table,
    input  logic [SW-1:0]               sel,
    output logic [WIDTH-1:0]            set_vec,
    output logic [WIDTH-1:0]            clr_vec
);
    import tw_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] code;
        force_t     fv;

        // Multiplex this bit's code out of the selected session
        always_comb begin
            code = 2'b00;
            for (int s = 0; s < SESSIONS; s++) begin
                if (sel == SW'(s))
                    code = weight_table[2*(s*WIDTH+i) +: 2];
            end
            fv = decode_weight(code);
        end

        assign set_vec[i] = fv.set_a;
        assign clr_vec[i] = fv.clr_a;
    end

endmodule

// File: rtl/tw_adder.sv
// Accumulator adder.
// Plain WIDTH-bit adder with no carry-in and the carry-out dropped. The
// USE_PREFIX parameter picks a ripple chain or a parallel-prefix carry
// network; the sums are identical. Assumes WIDTH >= 2.
module tw_adder #(
    parameter int WIDTH      = 5,
    parameter bit USE_PREFIX = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] carry_in;

    // Carry into each bit through a serial chain
    function automatic logic [WIDTH-1:0] ripple_carries(
        input logic [WIDTH-1:0] g,
        input logic [WIDTH-1:0] p
    );
        logic [WIDTH-1:0] c;
        c = '0;
        for (int i = 1; i < WIDTH; i++)
            c[i] = g[i-1] | (p[i-1] & c[i-1]);
        return c;
    endfunction

    // Carry into each bit through log2(WIDTH) levels of prefix combining
    function automatic logic [WIDTH-1:0] prefix_carries(
        input logic [WIDTH-1:0] g,
        input logic [WIDTH-1:0] p
    );
        logic [WIDTH-1:0] gx;
        logic [WIDTH-1:0] px;
        gx = g;
        px = p;
        for (int d = 1; d < WIDTH; d = d * 2) begin
            gx = gx | (px & (gx << d));
            px = px & (px << d);
        end
        return {gx[WIDTH-2:0], 1'b0};
    endfunction

    // Bitwise generate and propagate terms
    always_comb begin
        gen  = a & b;
        prop = a ^ b;
    end

    if (USE_PREFIX) begin : g_prefix
        // Parallel-prefix carry network
        always_comb carry_in = prefix_carries(gen, prop);
    end else begin : g_ripple
        // Ripple carry chain
        always_comb carry_in = ripple_carries(gen, prop);
    end

    // Sum bits
    always_comb sum = prop ^ carry_in;

endmodule

// File: rtl/tw_acc_bit.sv
// One accumulator bit pair.
// Holds A[i] and B[i]. A write takes the adder sum into A, or 0 on the
// load write. Set/clear dominate: set forces A=1, B=0 and clear forces
// A=0, B=1, so the adder stage passes its carry straight through.
// B otherwise takes the operand bit. Set and clear are never both high.
module tw_acc_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic clear_free,
    input  logic set_a,
    input  logic clr_a,
    input  logic sum_bit,
    input  logic op_bit,
    output logic a_q,
    output logic b_q
);

    // Pattern bit with synchronous set/clear override
    always_ff @(posedge clk) begin
        if (!rst_n)
            a_q <= 1'b0;
        else if (wr) begin
            if (set_a)
                a_q <= 1'b1;
            else if (clr_a)
                a_q <= 1'b0;
            else
                a_q <= clear_free ? 1'b0 : sum_bit;
        end
    end

    // Operand bit, its set/clear lines crossed relative to A
    always_ff @(posedge clk) begin
        if (!rst_n)
            b_q <= 1'b0;
        else if (wr) begin
            if (set_a)
                b_q <= 1'b0;
            else if (clr_a)
                b_q <= 1'b1;
            else
                b_q <= op_bit;
        end
    end

endmodule

// File: rtl/tw_pattern_gen.sv
// Three-weight accumulator pattern generator (top).
// Register A plus register B feed an unmodified adder, and A takes the
// sum every clock. Per-session set/clear vectors pin chosen bits of A
// to 0 or 1 by writing complementary values into B, so those stages
// pass their carry through. The operand constant is captured at start.
// Assumes WIDTH >= 2, SESSIONS >= 1, SESSION_LEN >= 1.
module tw_pattern_gen #(
    parameter int WIDTH       = 5,
    parameter int SESSIONS    = 2,
    parameter int SESSION_LEN = 8,
    parameter bit USE_PREFIX  = 1'b0,
    localparam int SW = (SESSIONS > 1) ? $clog2(SESSIONS) : 1,
    localparam int CW = (SESSION_LEN > 1) ? $clog2(SESSION_LEN) : 1,
    localparam int TW = 2 * SESSIONS * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] addend,
    input  logic [TW-1:0]    weight_table,
    output logic [WIDTH-1:0] pattern,
    output logic [SW-1:0]    session_idx,
    output logic             done
);

    logic             load;
    logic             step;
    logic             wr;
    logic             busy;
    logic [SW-1:0]    apply_sess;
    logic [WIDTH-1:0] force_set;
    logic [WIDTH-1:0] force_clr;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opnd_q;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] op_hold_q;
    logic [WIDTH-1:0] op_src;

    tw_session_ctrl #(
        .SESSIONS   (SESSIONS),
        .SESSION_LEN(SESSION_LEN),
        .SW         (SW),
        .CW         (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step      (step),
        .apply_sess(apply_sess),
        .sess_q    (session_idx),
        .busy_q    (busy),
        .done_q    (done)
    );

    tw_force_decode #(
        .WIDTH   (WIDTH),
        .SESSIONS(SESSIONS),
        .SW      (SW)
    ) u_dec (
        .weight_table(weight_table),
        .sel         (apply_sess),
        .set_vec     (force_set),
        .clr_vec     (force_clr)
    );

    tw_adder #(
        .WIDTH     (WIDTH),
        .USE_PREFIX(USE_PREFIX)
    ) u_add (
        .a  (acc_q),
        .b  (opnd_q),
        .sum(sum)
    );

    // Any register write: the load or a step
    always_comb wr = load || step;

    // Capture the operand constant when a run starts
    always_ff @(posedge clk) begin
        if (!rst_n)
            op_hold_q <= '0;
        else if (load)
            op_hold_q <= addend;
    end

    // B's free bits take the live operand on the load, the held copy after
    always_comb op_src = load ? addend : op_hold_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        tw_acc_bit u_bit (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr),
            .clear_free(load),
            .set_a     (force_set[i]),
            .clr_a     (force_clr[i]),
            .sum_bit   (sum[i]),
            .op_bit    (op_src[i]),
            .a_q       (acc_q[i]),
            .b_q       (opnd_q[i])
        );
    end

    assign pattern = acc_q;

endmodule

// File: rtl/tw_checker.sv
// Property checker for tw_pattern_gen, attached by bind.
// Watches the forcing vectors, the two registers and the run flags.
module tw_checker #(
    parameter int WIDTH    = 5,
    parameter int SESSIONS = 2,
    parameter int SW       = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             wr,
    input logic             busy,
    input logic [WIDTH-1:0] set_vec,
    input logic [WIDTH-1:0] clr_vec,
    input logic [WIDTH-1:0] pattern,
    input logic [WIDTH-1:0] opnd,
    input logic [SW-1:0]    session_idx,
    input logic             done
);

    assert_force_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((pattern & $past(set_vec)) == $past(set_vec)));

    assert_force_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((pattern & $past(clr_vec)) == '0));

    assert_operand_complement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (((pattern ^ opnd) & $past(set_vec | clr_vec)) == $past(set_vec | clr_vec)));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pattern) && $stable(session_idx)));

    assert_done_last_session_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (session_idx == SW'(SESSIONS - 1)));

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && busy && session_idx == '0));

endmodule

bind tw_pattern_gen tw_checker #(
    .WIDTH   (WIDTH),
    .SESSIONS(SESSIONS),
    .SW      (SW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wr         (wr),
    .busy       (busy),
    .set_vec    (force_set),
    .clr_vec    (force_clr),
    .pattern    (pattern),
    .opnd       (opnd_q),
    .session_idx(session_idx),
    .done       (done)
);

// File: tb/tw_pattern_gen_bench.sv
module tw_pattern_gen_bench;
    localparam int W  = 5;
    localparam int K  = 2;
    localparam int L  = 8;
    localparam int SW = 1;
    localparam int TW = 2 * K * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  addend = '0;
    logic [TW-1:0] weights = '0;
    logic [W-1:0]  pat_r, pat_p;
    logic [SW-1:0] sess_r, sess_p;
    logic          done_r, done_p;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tw_pattern_gen #(.WIDTH(W), .SESSIONS(K), .SESSION_LEN(L), .USE_PREFIX(1'b0)) u_tw_pattern_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .addend(addend), .weight_table(weights),
        .pattern(pat_r), .session_idx(sess_r), .done(done_r));

    tw_pattern_gen #(.WIDTH(W), .SESSIONS(K), .SESSION_LEN(L), .USE_PREFIX(1'b1)) u_tw_pattern_gen_pfx (
        .clk(clk), .rst_n(rst_n), .start(start), .addend(addend), .weight_table(weights),
        .pattern(pat_p), .session_idx(sess_p), .done(done_p));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected A after forcing (R3: 10 -> 1, 01 -> 0, else free)
    function automatic logic [W-1:0] force_a(input logic [W-1:0] v, input int s, input logic [TW-1:0] t);
        logic [W-1:0] r = v;
        for (int i = 0; i < W; i++) begin
            if (t[2*(s*W+i) +: 2] == 2'b10) r[i] = 1'b1;
            else if (t[2*(s*W+i) +: 2] == 2'b01) r[i] = 1'b0;
        end
        return r;
    endfunction

    // Expected B: complement of forced A bits, operand elsewhere (R5)
    function automatic logic [W-1:0] force_b(input logic [W-1:0] op, input int s, input logic [TW-1:0] t);
        logic [W-1:0] r = op;
        for (int i = 0; i < W; i++) begin
            if (t[2*(s*W+i) +: 2] == 2'b10) r[i] = 1'b0;
            else if (t[2*(s*W+i) +: 2] == 2'b01) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [TW-1:0] rand_table();
        logic [TW-1:0] t;
        for (int i = 0; i < TW; i++) t[i] = 1'($urandom);
        return t;
    endfunction

    // One complete run, checked pattern by pattern
    task automatic run(input logic [TW-1:0] tbl, input logic [W-1:0] op,
                       input bit poke_start, input bit poke_addend);
        logic [W-1:0] ea, eb, tmp;
        @(negedge clk);
        weights = tbl;
        addend  = op;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ea = force_a('0, 0, tbl);
        eb = force_b(op, 0, tbl);
        for (int p = 0; p < K*L; p++) begin
            if (p > 0) begin
                @(negedge clk);
                start = 1'b0;
                tmp = ea + eb;
                ea  = force_a(tmp, p / L, tbl);
                eb  = force_b(op, p / L, tbl);
            end
            if (p == 0) begin
                check("R2 first pattern", pat_r, ea);
                check("R10 done cleared by start", done_r, 0);
            end else begin
                check("R6 R4 pattern", pat_r, ea);
            end
            check("R7 session index", sess_r, p / L);
            check("R11 prefix matches ripple", pat_p, pat_r);
            if (poke_addend) addend = W'($urandom);
            if (poke_start && p == 3) start = 1'b1;  // R9 stray start mid-run
        end
        @(negedge clk);
        start = 1'b0;
        check("R8 done raised", done_r, 1);
        check("R8 pattern held", pat_r, ea);
        check("R8 session last", sess_r, K - 1);
        @(negedge clk);
        check("R8 still held", pat_r, ea);
        check("R8 still done", done_r, 1);
    endtask

    // Watchdog
    initial begin
        #(100000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ref_t;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset pattern", pat_r, 0);
        check("R1 reset session", sess_r, 0);
        check("R1 reset done", done_r, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle pattern", pat_r, 0);
        check("R1 idle done", done_r, 0);

        // Reference case, bits 4..0: s0 {r,r,1,r,1}, s1 {r,r,0,1,0}
        ref_t = '0;
        ref_t[2*(0*W+0) +: 2] = 2'b10;
        ref_t[2*(0*W+2) +: 2] = 2'b10;
        ref_t[2*(1*W+0) +: 2] = 2'b01;
        ref_t[2*(1*W+1) +: 2] = 2'b10;
        ref_t[2*(1*W+2) +: 2] = 2'b01;
        run(ref_t, 5'b01011, 1'b0, 1'b0);
        // R3: code 11 acts as random, all-random and all-forced tables
        run({TW{1'b1}}, 5'b00101, 1'b0, 1'b0);
        run('0, 5'b00001, 1'b0, 1'b0);
        run({K*W{2'b01}}, 5'b10111, 1'b0, 1'b0);
        // R9 stray start, R12 addend changes in mid-run
        run(ref_t, 5'b00111, 1'b1, 1'b0);
        run(ref_t, 5'b10011, 1'b0, 1'b1);
        for (int n = 0; n < 8; n++)
            run(rand_table(), W'($urandom), n[0], n[1]);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule